// File: doc/BRIEF.md
# CCD Binning Readout Clock Sequencer

This block produces the digital clock pattern that reads a CCD array out through its parallel register, serial register and summing well, with charge binning set at run time. A frame starts on a start strobe. The block then steps the parallel register several times so that a number of rows pile up in the serial register. Next it shifts the serial register several times into the summing well, so that a number of columns pile up there too. Finally it dumps the summed packet to the output node and raises a sample strobe for that super pixel.

The horizontal and vertical bin factors are independent. Either can be anything from 1, which gives plain unbinned readout, up to almost the full array. When the array size is not a multiple of a bin factor, the last group is shorter, so the shift totals always equal the array size. Every shift or dump pulse has a programmable length, and at least one idle cycle separates consecutive pulses. Progress outputs give the zero-based row group and column group of the super pixel being sampled.

Top module: `ccd_bin_sequencer`

## Requirements
- R1: After reset, all three clock pulses, the sample strobe, done and busy are low, and both progress counts are zero.
- R2: A start seen while idle captures the array size, both bin factors and the pulse length, and raises busy until done. A start or configuration change while busy has no effect on the frame in progress.
- R3: Each row group gets min(V, rows left) parallel pulses in a row, with no serial pulse or dump between them. A vertical factor of 0 is treated as 1.
- R4: For each super pixel, min(H, columns left) serial pulses come first, then exactly one dump pulse. A horizontal factor of 0 is treated as 1.
- R5: Every dump pulse is followed, in the cycle right after it ends, by a one-cycle sample strobe. A frame has ceil(W/H)·ceil(Rows/V) samples.
- R6: Per frame, the parallel pulse total equals the row count and each row group's serial pulse total equals the column count. A width or height of 0 is treated as 1.
- R7: Each pulse stays high for max(1, length) cycles. Consecutive pulses are separated by exactly one idle cycle.
- R8: At most one of the parallel, serial and dump pulses is high at any time.
- R9: done is high for one cycle, together with the final sample strobe. busy is low in the following cycle.
- R10: During each sample strobe, the row-group and column-group outputs hold the zero-based indices of the super pixel being sampled, in row-major order.
- R11: With both factors set to 1, each row gets one parallel pulse and each pixel gets one serial pulse, one dump and one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (honoured only while idle) |
| cfg_cols | input | COL_W | Array width in pixels |
| cfg_rows | input | ROW_W | Array height in pixels |
| cfg_hbin | input | BIN_W | Horizontal bin factor |
| cfg_vbin | input | BIN_W | Vertical bin factor |
| cfg_plen | input | PLEN_W | Pulse length in cycles |
| par_shift | output | 1 | Parallel register clock pulse |
| ser_shift | output | 1 | Serial register clock pulse |
| sum_dump | output | 1 | Summing-well transfer pulse |
| sample | output | 1 | One-cycle strobe per super pixel |
| done | output | 1 | Frame finished |
| busy | output | 1 | Frame in progress |
| row_grp | output | ROW_W | Current row-group index |
| col_grp | output | COL_W | Current column-group index |

## Verification
Some rules are checked by the assertions on every cycle: the pulses are mutually exclusive, pulses are separated by idle cycles, pulse width matches the captured length, a sample follows only a dump, done is a single cycle coinciding with a sample, and the group counters stay within bounds. Other properties are frame-level and only the bench scenarios can show them. These are the ordering of parallel, serial and dump pulses, the per-group pulse totals with uneven edge groups, the progress indices, the handling of zero settings, and the fact that a start or configuration change in mid-frame is ignored. The bench checks them against a charge-packet model of the readout.

// File: rtl/ccd_bin_pkg.sv
package ccd_bin_pkg;

   // Which clock the pulse engine is currently producing
   typedef enum logic [1:0] {
      K_PAR  = 2'd0,
      K_SER  = 2'd1,
      K_DUMP = 2'd2
   } kind_t;

   // Pulse engine phase
   typedef enum logic [1:0] {
      E_IDLE = 2'd0,
      E_ON   = 2'd1,
      E_GAP  = 2'd2
   } eng_st_t;

endpackage

// File: rtl/ccd_pulse_engine.sv
module ccd_pulse_engine
   import ccd_bin_pkg::*;
#(
   parameter int PLEN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [PLEN_W-1:0] len,
   output logic              on,
   output logic              gap
);

   eng_st_t           st_q;
   logic [PLEN_W-1:0] cnt_q;
   logic [PLEN_W-1:0] len_q;
   logic [PLEN_W:0]   wid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= E_IDLE;
         cnt_q <= '0;
         len_q <= PLEN_W'(1);
      end else begin
         unique case (st_q)
            E_IDLE: begin
               if (launch) begin
                  st_q  <= E_ON;
                  cnt_q <= len - PLEN_W'(1);
                  len_q <= len;
               end
            end
            E_ON: begin
               if (cnt_q == '0) st_q <= E_GAP;
               else             cnt_q <= cnt_q - PLEN_W'(1);
            end
            E_GAP: begin
               if (launch) begin
                  st_q  <= E_ON;
                  cnt_q <= len - PLEN_W'(1);
                  len_q <= len;
               end else begin
                  st_q <= E_IDLE;
               end
            end
            default: st_q <= E_IDLE;
         endcase
      end
   end

   // Independent width tally, used only by the width check
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            wid_q <= '0;
      else if (st_q == E_ON) wid_q <= wid_q + (PLEN_W+1)'(1);
      else                   wid_q <= '0;
   end

   assign on  = (st_q == E_ON);
   assign gap = (st_q == E_GAP);

   // R7: a high phase lasts exactly the captured length
   a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == E_GAP) |-> (wid_q == {1'b0, len_q}));

   // R7: the engine never jumps from one high phase to another
   a_r7_gap_follows_on: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(on) |-> gap);

endmodule

// File: rtl/ccd_bin_group_ctr.sv
module ccd_bin_group_ctr #(
   parameter int LEN_W = 12,
   parameter int BIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             close,
   input  logic             adv,
   input  logic [LEN_W-1:0] total,
   input  logic [BIN_W-1:0] bin,
   output logic             grp_last,
   output logic             all_done,
   output logic [LEN_W-1:0] idx
);

   logic [LEN_W-1:0] rem_q;
   logic [LEN_W-1:0] idx_q;
   logic [BIN_W-1:0] in_q;
   logic [BIN_W:0]   in_nx;

   assign in_nx    = {1'b0, in_q} + (BIN_W+1)'(1);
   assign grp_last = (in_nx == {1'b0, bin}) || (rem_q == LEN_W'(1));
   assign all_done = (rem_q == '0);
   assign idx      = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         idx_q <= '0;
         in_q  <= '0;
      end else if (load) begin
         rem_q <= total;
         idx_q <= '0;
         in_q  <= '0;
      end else begin
         if (step)       rem_q <= rem_q - LEN_W'(1);
         if (close)      in_q  <= '0;
         else if (step)  in_q  <= in_nx[BIN_W-1:0];
         if (adv)        idx_q <= idx_q + LEN_W'(1);
      end
   end

   // R6: never step past the end of the array
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |-> (rem_q != '0));

   // R3/R4: the in-group count stays below the bin factor
   a_r4_group_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, in_q} < {1'b0, bin}));

endmodule

// File: rtl/ccd_strobe_stage.sv
module ccd_strobe_stage #(
   parameter int W       = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (OUT_REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_thru
      assign q = d;
   end

endmodule

// File: rtl/ccd_bin_sequencer.sv
module ccd_bin_sequencer
   import ccd_bin_pkg::*;
#(
   parameter int COL_W   = 12,
   parameter int ROW_W   = 12,
   parameter int BIN_W   = 8,
   parameter int PLEN_W  = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [COL_W-1:0]  cfg_cols,
   input  logic [ROW_W-1:0]  cfg_rows,
   input  logic [BIN_W-1:0]  cfg_hbin,
   input  logic [BIN_W-1:0]  cfg_vbin,
   input  logic [PLEN_W-1:0] cfg_plen,
   output logic              par_shift,
   output logic              ser_shift,
   output logic              sum_dump,
   output logic              sample,
   output logic              done,
   output logic              busy,
   output logic [ROW_W-1:0]  row_grp,
   output logic [COL_W-1:0]  col_grp
);

   localparam int STG_W = 6 + ROW_W + COL_W;

   if (BIN_W > COL_W || BIN_W > ROW_W) begin : g_bad_bin
      $error("BIN_W must not exceed COL_W or ROW_W");
   end
   if (PLEN_W < 1 || BIN_W < 1) begin : g_bad_w
      $error("PLEN_W and BIN_W must be at least 1");
   end

   // Zero settings are treated as one
   logic [COL_W-1:0]  cols_c;
   logic [ROW_W-1:0]  rows_c;
   logic [BIN_W-1:0]  hbin_c, vbin_c;
   logic [PLEN_W-1:0] plen_c;

   assign cols_c = (cfg_cols == '0) ? COL_W'(1)  : cfg_cols;
   assign rows_c = (cfg_rows == '0) ? ROW_W'(1)  : cfg_rows;
   assign hbin_c = (cfg_hbin == '0) ? BIN_W'(1)  : cfg_hbin;
   assign vbin_c = (cfg_vbin == '0) ? BIN_W'(1)  : cfg_vbin;
   assign plen_c = (cfg_plen == '0) ? PLEN_W'(1) : cfg_plen;

   // Frame configuration held for the whole frame
   logic [COL_W-1:0]  cols_q;
   logic [ROW_W-1:0]  rows_q;
   logic [BIN_W-1:0]  hbin_q, vbin_q;
   logic [PLEN_W-1:0] plen_q;
   logic              busy_q;
   kind_t             kind_q, kind_d;

   logic accept;
   assign accept = start && !busy_q;

   logic eng_on, eng_gap, eng_launch;
   logic [PLEN_W-1:0] eng_len;

   logic v_step, v_close, v_adv, v_last, v_done;
   logic h_load, h_step, h_close, h_adv, h_last, h_done;
   logic smp_raw, fin;
   logic [ROW_W-1:0] v_idx;
   logic [COL_W-1:0] h_idx;

   // Sequencing decisions are taken in the idle cycle after each pulse
   always_comb begin
      kind_d     = kind_q;
      eng_launch = 1'b0;
      v_step     = 1'b0;
      v_close    = 1'b0;
      v_adv      = 1'b0;
      h_load     = 1'b0;
      h_step     = 1'b0;
      h_close    = 1'b0;
      h_adv      = 1'b0;
      smp_raw    = 1'b0;
      fin        = 1'b0;
      if (accept) begin
         kind_d     = K_PAR;
         eng_launch = 1'b1;
      end else if (busy_q && eng_gap) begin
         unique case (kind_q)
            K_PAR: begin
               v_step     = 1'b1;
               eng_launch = 1'b1;
               if (v_last) begin
                  v_close = 1'b1;
                  h_load  = 1'b1;
                  kind_d  = K_SER;
               end
            end
            K_SER: begin
               h_step     = 1'b1;
               eng_launch = 1'b1;
               if (h_last) begin
                  h_close = 1'b1;
                  kind_d  = K_DUMP;
               end
            end
            K_DUMP: begin
               smp_raw = 1'b1;
               h_adv   = 1'b1;
               if (h_done) begin
                  v_adv = 1'b1;
                  if (v_done) begin
                     fin = 1'b1;
                  end else begin
                     kind_d     = K_PAR;
                     eng_launch = 1'b1;
                  end
               end else begin
                  kind_d     = K_SER;
                  eng_launch = 1'b1;
               end
            end
            default: kind_d = K_PAR;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         kind_q <= K_PAR;
         cols_q <= COL_W'(1);
         rows_q <= ROW_W'(1);
         hbin_q <= BIN_W'(1);
         vbin_q <= BIN_W'(1);
         plen_q <= PLEN_W'(1);
      end else begin
         kind_q <= kind_d;
         if (accept) begin
            busy_q <= 1'b1;
            cols_q <= cols_c;
            rows_q <= rows_c;
            hbin_q <= hbin_c;
            vbin_q <= vbin_c;
            plen_q <= plen_c;
         end else if (fin) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign eng_len = accept ? plen_c : plen_q;

   ccd_pulse_engine #(.PLEN_W(PLEN_W)) u_engine (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (eng_launch),
      .len    (eng_len),
      .on     (eng_on),
      .gap    (eng_gap)
   );

   // Vertical (row) grouping
   ccd_bin_group_ctr #(.LEN_W(ROW_W), .BIN_W(BIN_W)) u_vctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .step     (v_step),
      .close    (v_close),
      .adv      (v_adv),
      .total    (rows_c & {ROW_W{accept}} | rows_q & {ROW_W{!accept}}),
      .bin      (vbin_q),
      .grp_last (v_last),
      .all_done (v_done),
      .idx      (v_idx)
   );

   // Horizontal (column) grouping, reloaded for each row group
   ccd_bin_group_ctr #(.LEN_W(COL_W), .BIN_W(BIN_W)) u_hctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (h_load),
      .step     (h_step),
      .close    (h_close),
      .adv      (h_adv),
      .total    (cols_q),
      .bin      (hbin_q),
      .grp_last (h_last),
      .all_done (h_done),
      .idx      (h_idx)
   );

   logic par_raw, ser_raw, dump_raw, done_raw;
   assign par_raw  = eng_on && (kind_q == K_PAR);
   assign ser_raw  = eng_on && (kind_q == K_SER);
   assign dump_raw = eng_on && (kind_q == K_DUMP);
   assign done_raw = fin;

   logic [STG_W-1:0] stg_d, stg_q;
   assign stg_d = {par_raw, ser_raw, dump_raw, smp_raw, done_raw, busy_q, v_idx, h_idx};

   ccd_strobe_stage #(.W(STG_W), .OUT_REG(OUT_REG)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (stg_d),
      .q     (stg_q)
   );

   assign par_shift = stg_q[STG_W-1];
   assign ser_shift = stg_q[STG_W-2];
   assign sum_dump  = stg_q[STG_W-3];
   assign sample    = stg_q[STG_W-4];
   assign done      = stg_q[STG_W-5];
   assign busy      = stg_q[STG_W-6];
   assign row_grp   = stg_q[ROW_W+COL_W-1:COL_W];
   assign col_grp   = stg_q[COL_W-1:0];

   // R8: the three clock pulses never overlap
   a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({par_shift, ser_shift, sum_dump}));

   // R7: a new pulse only starts after a cycle with no pulse at all
   a_r7_idle_between: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(par_shift) || $rose(ser_shift) || $rose(sum_dump))
      |-> $past(!(par_shift || ser_shift || sum_dump)));

   // R5: a sample strobe only directly after a dump pulse
   a_r5_sample_after_dump: assert property (@(posedge clk) disable iff (!rst_n)
      sample |-> $past(sum_dump));

   // R5: sample lasts one cycle
   a_r5_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
      sample |=> !sample);

   // R9: done is a lone cycle aligned with the final sample
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sample);
   a_r9_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R2: busy ends only through done
   a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

   // R2: no pulse outside a frame
   a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !$past(busy_q)) |-> !eng_on);

endmodule

// File: tb/ccd_bin_sequencer_bench.sv
module ccd_bin_sequencer_bench;

   localparam int COL_W  = 12;
   localparam int ROW_W  = 12;
   localparam int BIN_W  = 8;
   localparam int PLEN_W = 4;

   localparam int EV_PAR  = 0;
   localparam int EV_SER  = 1;
   localparam int EV_DMP  = 2;
   localparam int EV_SMP  = 3;
   localparam int EV_DONE = 4;

   typedef struct {
      int kind;
      int row;
      int col;
   } ev_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [COL_W-1:0]  cfg_cols = '0;
   logic [ROW_W-1:0]  cfg_rows = '0;
   logic [BIN_W-1:0]  cfg_hbin = '0;
   logic [BIN_W-1:0]  cfg_vbin = '0;
   logic [PLEN_W-1:0] cfg_plen = '0;
   logic par_shift, ser_shift, sum_dump, sample, done, busy;
   logic [ROW_W-1:0] row_grp;
   logic [COL_W-1:0] col_grp;

   int checks = 0;
   int errors = 0;
   ev_t exp_q[$];
   int cur_len = 1;
   bit frame_done = 1'b0;
   string frame_name = "";

   always #4 clk = ~clk;

   ccd_bin_sequencer u_ccd_bin_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
      .cfg_hbin(cfg_hbin), .cfg_vbin(cfg_vbin), .cfg_plen(cfg_plen),
      .par_shift(par_shift), .ser_shift(ser_shift), .sum_dump(sum_dump),
      .sample(sample), .done(done), .busy(busy),
      .row_grp(row_grp), .col_grp(col_grp)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s [%s] actual=%0d expected=%0d", req, what, frame_name, act, exp);
      end
   endtask

   function automatic string req_of(input int k);
      case (k)
         EV_PAR:  return "R3";
         EV_SER:  return "R4";
         EV_DMP:  return "R4";
         EV_SMP:  return "R5";
         default: return "R9";
      endcase
   endfunction

   // Monitor: pops the scoreboard as events appear
   task automatic got(input int k, input int r, input int c);
      ev_t e;
      if (exp_q.size() == 0) begin
         check(1'b0, req_of(k), "unexpected event kind", k, -1);
         return;
      end
      e = exp_q.pop_front();
      check(e.kind == k, req_of(e.kind), "event order kind", k, e.kind);
      if (k == EV_SMP && e.kind == EV_SMP) begin
         check(r == e.row, "R10", "row group index", r, e.row);
         check(c == e.col, "R10", "column group index", c, e.col);
      end
   endtask

   logic p_par = 0, p_ser = 0, p_dmp = 0, p_smp = 0, p_any = 0;
   int hi_cnt = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_par = 0; p_ser = 0; p_dmp = 0; p_smp = 0; p_any = 0; hi_cnt = 0;
      end else begin
         if ((int'(par_shift) + int'(ser_shift) + int'(sum_dump)) > 1)
            check(1'b0, "R8", "pulses overlap", 2, 1);
         if ((par_shift && !p_par) || (ser_shift && !p_ser) || (sum_dump && !p_dmp))
            check(!p_any, "R7", "idle cycle before pulse", int'(p_any), 0);
         if (par_shift && !p_par) got(EV_PAR, 0, 0);
         if (ser_shift && !p_ser) got(EV_SER, 0, 0);
         if (sum_dump && !p_dmp)  got(EV_DMP, 0, 0);
         if (sample) begin
            if (p_smp) check(1'b0, "R5", "sample longer than one cycle", 2, 1);
            got(EV_SMP, int'(row_grp), int'(col_grp));
         end
         if (done) begin
            got(EV_DONE, 0, 0);
            check(exp_q.size() == 0, "R6", "leftover expected events", exp_q.size(), 0);
            frame_done = 1'b1;
         end
         if (par_shift || ser_shift || sum_dump) hi_cnt++;
         else if (hi_cnt != 0) begin
            check(hi_cnt == cur_len, "R7", "pulse width", hi_cnt, cur_len);
            hi_cnt = 0;
         end
         p_par = par_shift; p_ser = ser_shift; p_dmp = sum_dump;
         p_smp = sample;    p_any = par_shift | ser_shift | sum_dump;
      end
   end

   // Driver: builds the charge-packet model and starts the frame
   task automatic run_frame(input string name, input int cols, input int rows,
                            input int h, input int v, input int len,
                            input bit poke_mid);
      int cc, rr, hh, vv, g;
      frame_name = name;
      cc = (cols == 0) ? 1 : cols;
      rr = (rows == 0) ? 1 : rows;
      hh = (h == 0) ? 1 : h;
      vv = (v == 0) ? 1 : v;
      cur_len = (len == 0) ? 1 : len;
      g = 0;
      for (int r0 = 0; r0 < rr; r0 += vv) begin
         int vc, cg;
         vc = (rr - r0 < vv) ? rr - r0 : vv;
         for (int i = 0; i < vc; i++) exp_q.push_back('{EV_PAR, 0, 0});
         cg = 0;
         for (int c0 = 0; c0 < cc; c0 += hh) begin
            int hc;
            hc = (cc - c0 < hh) ? cc - c0 : hh;
            for (int j = 0; j < hc; j++) exp_q.push_back('{EV_SER, 0, 0});
            exp_q.push_back('{EV_DMP, 0, 0});
            exp_q.push_back('{EV_SMP, g, cg});
            cg++;
         end
         g++;
      end
      exp_q.push_back('{EV_DONE, 0, 0});
      frame_done = 1'b0;
      @(negedge clk);
      cfg_cols = COL_W'(cols);
      cfg_rows = ROW_W'(rows);
      cfg_hbin = BIN_W'(h);
      cfg_vbin = BIN_W'(v);
      cfg_plen = PLEN_W'(len);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
      if (poke_mid) begin
         repeat (4) @(negedge clk);
         cfg_cols = COL_W'(3);
         cfg_rows = ROW_W'(2);
         cfg_hbin = BIN_W'(7);
         cfg_vbin = BIN_W'(5);
         cfg_plen = PLEN_W'(9);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!frame_done) @(negedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R9", "busy low after done", int'(busy), 0);
      check(done == 1'b0, "R9", "done single cycle", int'(done), 0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!par_shift && !ser_shift && !sum_dump, "R1", "pulses in reset",
            int'({par_shift, ser_shift, sum_dump}), 0);
      check(!sample && !done && !busy, "R1", "strobes in reset",
            int'({sample, done, busy}), 0);
      check(row_grp == '0 && col_grp == '0, "R1", "progress in reset",
            int'(row_grp) + int'(col_grp), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !par_shift, "R1", "idle after reset", int'(busy), 0);

      run_frame("R11 unbinned 5x4",        5, 4, 1, 1, 1, 1'b0);
      run_frame("R3 R4 even 2x2 8x6",      8, 6, 2, 2, 2, 1'b0);
      run_frame("R6 uneven 3x4 on 10x7",  10, 7, 3, 4, 3, 1'b0);
      run_frame("R2 mid-frame poke",       6, 5, 2, 3, 2, 1'b1);
      run_frame("R5 near-full bin",        9, 7, 8, 6, 1, 1'b0);
      run_frame("R3 R4 zero factors",      3, 2, 0, 0, 0, 1'b0);
      run_frame("R6 zero size",            0, 0, 2, 2, 4, 1'b0);
      run_frame("R4 wide horizontal only", 7, 3, 7, 1, 1, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired [%s] actual=%0d expected=%0d", frame_name, 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule